// File: doc/BRIEF.md
# Byte-Lane Data Memory

This block is a 32-bit wide data store whose addresses count bytes. One access is made per clock. A 2-bit operation code selects a whole-word read or a store of one byte, one halfword or one full word. Byte and halfword stores change only the byte lanes they cover, and the rest of the word keeps its old contents. Bytes inside a word are little endian: the byte at the lowest address sits in the least significant bits.

Storage is split into four byte-wide banks, one for each lane, so that each bank maps onto an inferred block RAM with a registered output. A lane-select stage turns the operation code and the two low address bits into per-lane write enables. A steering stage copies the low bits of the write value onto every lane that could receive them. The word index comes from the address bits above the byte offset. Address bits above the index are not decoded, so the store repeats through the address space.

Top module: `byte_mem_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `rd_data` is set to zero at that edge.
- R2: With `mem_en` high and `mem_op` = 00 (word read), `rd_data` returns the stored word containing `addr` after the next rising edge. `addr[1:0]` are ignored.
- R3: With `mem_en` high and `mem_op` = 01 (byte store), `wr_data[7:0]` is written to lane `addr[1:0]` of the addressed word. The other three lanes are unchanged.
- R4: With `mem_en` high and `mem_op` = 10 (halfword store), `wr_data[15:0]` is written to lanes 1..0 when `addr[1]` is 0, and to lanes 3..2 when `addr[1]` is 1. `addr[0]` is ignored, and the other two lanes are unchanged.
- R5: With `mem_en` high and `mem_op` = 11 (word store), all 32 bits of `wr_data` are written to the addressed word. `addr[1:0]` are ignored.
- R6: Lane k of a word is the byte at byte offset k. It occupies bits 8k+7..8k of the word, so within a halfword store `wr_data[7:0]` goes to the lower address.
- R7: With `mem_en` low, no stored byte changes, whatever `mem_op` is, and `rd_data` keeps its value.
- R8: A store cycle leaves `rd_data` unchanged.
- R9: The word index is `addr[IDX_W+1:2]`, where IDX_W = log2(DEPTH_WORDS). Higher address bits are ignored, so addresses that differ only there reach the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the read register |
| mem_en | input | 1 | Access enable |
| mem_op | input | 2 | 00 word read, 01 byte store, 10 halfword store, 11 word store |
| addr | input | ADDR_W | Byte address |
| wr_data | input | 32 | Store value; low bits used for narrow stores |
| rd_data | output | 32 | Registered read word |

## Verification
Stores take effect at the rising edge where they are presented. A read presented at one edge shows its word on `rd_data` from just after that edge, so the bench drives each request on a falling edge and samples `rd_data` on the following falling edge, one full cycle later. The effect of each store is checked by a later read, and expected words come from a byte-accurate model in the bench that is updated from the requirements. The checks that `rd_data` holds are sampled in the cycle right after a disabled access or a store, before any other read is issued.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;
  localparam int OFS_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    MOP_RD_WORD = 2'b00,
    MOP_ST_BYTE = 2'b01,
    MOP_ST_HALF = 2'b10,
    MOP_ST_WORD = 2'b11
  } mem_op_e;

endpackage

// File: rtl/dmem_lane_sel.sv
module dmem_lane_sel
  import dmem_pkg::*;
(
  input  logic             en,
  input  mem_op_e          op,
  input  logic [OFS_W-1:0] ofs,
  output logic [LANES-1:0] lane_we,
  output logic             rd_req
);

  logic st_ok;
  assign st_ok  = en && (op != MOP_RD_WORD);
  assign rd_req = en && (op == MOP_RD_WORD);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [OFS_W-1:0] LANE_ID = OFS_W'(i);
    logic hit_byte, hit_half, hit_word;
    assign hit_byte = (op == MOP_ST_BYTE) && (ofs == LANE_ID);
    assign hit_half = (op == MOP_ST_HALF) && (ofs[OFS_W-1] == LANE_ID[OFS_W-1]);
    assign hit_word = (op == MOP_ST_WORD);
    assign lane_we[i] = st_ok && (hit_byte || hit_half || hit_word);
  end

endmodule

// File: rtl/dmem_lane_steer.sv
module dmem_lane_steer
  import dmem_pkg::*;
(
  input  mem_op_e                   op,
  input  logic [WORD_W-1:0]         wr_data,
  output logic [LANES-1:0][LANE_W-1:0] lane_din
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int HALF_SEL = i % (LANES / 2);
    always_comb begin
      unique case (op)
        MOP_ST_BYTE: lane_din[i] = wr_data[LANE_W-1:0];
        MOP_ST_HALF: lane_din[i] = wr_data[HALF_SEL*LANE_W +: LANE_W];
        default:     lane_din[i] = wr_data[i*LANE_W +: LANE_W];
      endcase
    end
  end

endmodule

// File: rtl/dmem_lane_ram.sv
module dmem_lane_ram #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             re,
  input  logic [AW-1:0]    idx,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst)     dout <= '0;
    else if (re) dout <= mem[idx];
  end

endmodule

// File: rtl/byte_mem_unit.sv
module byte_mem_unit
  import dmem_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DEPTH_WORDS = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mem_en,
  input  logic [1:0]        mem_op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data
);

  localparam int IDX_W = $clog2(DEPTH_WORDS);

  mem_op_e                      op;
  logic [IDX_W-1:0]             word_idx;
  logic [LANES-1:0]             lane_we;
  logic                         rd_req;
  logic [LANES-1:0][LANE_W-1:0] lane_din;
  logic [LANES-1:0][LANE_W-1:0] lane_dout;
  logic                         unused_addr_hi;

  assign op             = mem_op_e'(mem_op);
  assign word_idx       = addr[IDX_W+OFS_W-1:OFS_W];
  assign unused_addr_hi = ^addr[ADDR_W-1:IDX_W+OFS_W];

  dmem_lane_sel u_sel (
    .en      (mem_en),
    .op      (op),
    .ofs     (addr[OFS_W-1:0]),
    .lane_we (lane_we),
    .rd_req  (rd_req)
  );

  dmem_lane_steer u_steer (
    .op       (op),
    .wr_data  (wr_data),
    .lane_din (lane_din)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_bank
    dmem_lane_ram #(.DEPTH(DEPTH_WORDS), .WIDTH(LANE_W)) u_ram (
      .clk  (clk),
      .rst  (rst),
      .we   (lane_we[i]),
      .re   (rd_req),
      .idx  (word_idx),
      .din  (lane_din[i]),
      .dout (lane_dout[i])
    );
  end

  assign rd_data = lane_dout;

endmodule

// File: rtl/byte_mem_unit_chk.sv
module byte_mem_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        mem_en,
  input logic [1:0]  mem_op,
  input logic [1:0]  ofs,
  input logic [3:0]  lane_we,
  input logic [31:0] rd_data
);

  assert_rst_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> rd_data == 32'h0);

  assert_read_no_store_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_op == 2'b00) |-> lane_we == 4'b0000);

  assert_byte_lane_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_op == 2'b01) |-> ($countones(lane_we) == 1 && lane_we[ofs]));

  assert_half_lanes_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_op == 2'b10) |-> lane_we == (ofs[1] ? 4'b1100 : 4'b0011));

  assert_word_lanes_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_op == 2'b11) |-> lane_we == 4'b1111);

  assert_idle_no_store_R7: assert property (@(posedge clk) disable iff (rst)
    !mem_en |-> lane_we == 4'b0000);

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !mem_en |=> $stable(rd_data));

  assert_store_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_op != 2'b00) |=> $stable(rd_data));

endmodule

bind byte_mem_unit byte_mem_unit_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .mem_en  (mem_en),
  .mem_op  (mem_op),
  .ofs     (addr[1:0]),
  .lane_we (lane_we),
  .rd_data (rd_data)
);

// File: tb/tb_byte_mem_unit.sv
module tb_byte_mem_unit;

  localparam int ADDR_W = 32;
  localparam int DEPTH  = 64;

  logic              clk = 1'b0;
  logic              rst;
  logic              mem_en;
  logic [1:0]        mem_op;
  logic [ADDR_W-1:0] addr;
  logic [31:0]       wr_data;
  logic [31:0]       rd_data;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [31:0] model [DEPTH];

  always #2.5 clk = ~clk;

  byte_mem_unit #(.ADDR_W(ADDR_W), .DEPTH_WORDS(DEPTH)) dut (
    .clk (clk), .rst (rst), .mem_en (mem_en), .mem_op (mem_op),
    .addr (addr), .wr_data (wr_data), .rd_data (rd_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  function automatic int widx(input logic [ADDR_W-1:0] a);
    return int'(a[7:2]);
  endfunction

  // model of a store, built from R3..R6
  task automatic model_store(input logic [1:0] op, input logic [ADDR_W-1:0] a,
                             input logic [31:0] d);
    int w = widx(a);
    case (op)
      2'b01: model[w][8*a[1:0] +: 8] = d[7:0];
      2'b10: model[w][16*a[1] +: 16] = d[15:0];
      2'b11: model[w] = d;
      default: ;
    endcase
  endtask

  task automatic store(input logic [1:0] op, input logic [ADDR_W-1:0] a,
                       input logic [31:0] d);
    @(negedge clk);
    mem_en = 1'b1; mem_op = op; addr = a; wr_data = d;
    @(negedge clk);
    mem_en = 1'b0;
    model_store(op, a, d);
  endtask

  task automatic load(input logic [ADDR_W-1:0] a, output logic [31:0] r);
    @(negedge clk);
    mem_en = 1'b1; mem_op = 2'b00; addr = a;
    @(negedge clk);
    r = rd_data;
    mem_en = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset clears rd_data", rd_data, 32'h0);
    rst = 1'b0;
  endtask

  task automatic t_word;
    logic [31:0] r;
    store(2'b11, 32'h0000_0000, 32'hDEAD_BEEF);
    store(2'b11, 32'h0000_0014, 32'h0123_4567);
    store(2'b11, 32'h0000_00FF, 32'hCAFE_F00D); // R5 offset bits ignored -> word 63
    load(32'h0000_0000, r); check("R2/R5 word 0", r, model[0]);
    load(32'h0000_0017, r); check("R2 read offset 3 ignored", r, model[5]);
    load(32'h0000_00FC, r); check("R5 misaligned word store", r, 32'hCAFE_F00D);
    load(32'h0000_00FD, r); check("R2 read offset 1 ignored", r, model[63]);
  endtask

  task automatic t_bytes;
    logic [31:0] r;
    store(2'b11, 32'h0000_0028, 32'hA5A5_A5A5);
    for (int k = 0; k < 4; k++) begin
      store(2'b01, 32'h0000_0028 + k, 32'hFFFF_FF10 + k);
      load(32'h0000_0028, r);
      check($sformatf("R3 byte lane %0d", k), r, model[10]);
    end
    check("R3 all lanes final", model[10], 32'h1312_1110);
  endtask

  task automatic t_half;
    logic [31:0] r;
    store(2'b11, 32'h0000_0030, 32'h5A5A_5A5A);
    store(2'b10, 32'h0000_0032, 32'hFFFF_BEEF);
    load(32'h0000_0030, r); check("R4 upper half", r, 32'hBEEF_5A5A);
    store(2'b10, 32'h0000_0031, 32'h0000_1234); // addr[0] ignored -> lanes 1..0
    load(32'h0000_0030, r); check("R4 lower half, addr[0] ignored", r, 32'hBEEF_1234);
  endtask

  task automatic t_endian;
    logic [31:0] r;
    store(2'b11, 32'h0000_0040, 32'h1122_3344);
    store(2'b01, 32'h0000_0040, 32'h0000_00EE);
    load(32'h0000_0040, r); check("R6 offset 0 is low byte", r, 32'h1122_33EE);
    store(2'b01, 32'h0000_0043, 32'h0000_0077);
    load(32'h0000_0040, r); check("R6 offset 3 is high byte", r, 32'h7722_33EE);
  endtask

  task automatic t_disabled;
    logic [31:0] r;
    store(2'b11, 32'h0000_0050, 32'h600D_600D);
    load(32'h0000_0050, r);
    @(negedge clk);
    mem_en = 1'b0; mem_op = 2'b11; addr = 32'h0000_0050; wr_data = 32'hBAD0_BAD0;
    @(negedge clk);
    check("R7 rd_data held with enable low", rd_data, 32'h600D_600D);
    mem_op = 2'b00; addr = 32'h0000_0000;
    @(negedge clk);
    check("R7 disabled read leaves rd_data", rd_data, 32'h600D_600D);
    load(32'h0000_0050, r); check("R7 no store with enable low", r, 32'h600D_600D);
  endtask

  task automatic t_store_hold;
    logic [31:0] r;
    load(32'h0000_0014, r);
    @(negedge clk);
    mem_en = 1'b1; mem_op = 2'b11; addr = 32'h0000_0060; wr_data = 32'h1357_9BDF;
    @(negedge clk);
    mem_en = 1'b0;
    model_store(2'b11, 32'h0000_0060, 32'h1357_9BDF);
    check("R8 store leaves rd_data", rd_data, model[5]);
  endtask

  task automatic t_alias;
    logic [31:0] r;
    store(2'b11, 32'h8000_0104, 32'hA11A_5ED0); // index from bits 7:2 -> word 1
    load(32'h0000_0004, r); check("R9 upper address bits ignored", r, 32'hA11A_5ED0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; mem_en = 1'b0; mem_op = 2'b00; addr = '0; wr_data = '0;
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    t_word();
    t_bytes();
    t_half();
    t_endian();
    t_disabled();
    t_store_hold();
    t_alias();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule